// File: doc/BRIEF.md
# Windowed Register File with Overlapping Procedure Windows

This block is the integer register file for a processor whose procedures each see 32 architectural registers. Behind them sits a larger physical array of 8 shared registers plus 8 windows of 16 registers each, 136 entries in all. Architectural registers 0 to 7 always reach the shared entries, and register 0 is fixed at zero. Registers 8 to 31 go through a window chosen by a current-window pointer. Within a window, 8–15 are the outgoing argument registers, 16–23 are private to the procedure, and 24–31 are the incoming argument registers.

Adjacent windows overlap. The outgoing registers of a caller are the same physical entries as the incoming registers of the procedure it calls, so arguments pass without any copy. A save command moves the pointer down by one window and a restore moves it up by one, both modulo the window count. An invalid-window index, supplied as an input, marks the one window that cannot be entered. A save or restore that would land on it is refused, and the matching flag pulses instead. Spilling windows to memory is left to surrounding logic.

There are two combinational read ports and one write port. A write that targets the entry being read in the same cycle is forwarded to the read port.

Top module: `wrf_regfile`

## Requirements
- R1: After reset, the window pointer is 0, both flags are low, and every register reads 0.
- R2: Register 0 reads 0 on both read ports at all times, and a write to it changes nothing.
- R3: Registers 1–7 map to the same entries in every window. A value written to one of them is read back unchanged after any number of saves and restores.
- R4: Registers 16–23 are private to each window. A write to one in window w does not change the same register number in window w−1.
- R5: Register 8+i (i = 0..7) in window w is the same entry as register 24+i in window (w−1) mod 8. A value written there before a save reads back from register 24+i after it, and a value written to 24+i reads back from 8+i after the following restore.
- R6: When save alone is accepted, the pointer becomes (w−1) mod 8 at the next clock edge. When restore alone is accepted, it becomes (w+1) mod 8. In both cases `cwp_o` shows the new value from that edge onward.
- R7: A save alone is refused when (w−1) mod 8 equals `inv_win_i`. The pointer then stays unchanged, and `ovf_o` is high for exactly the one cycle after the command edge.
- R8: A restore alone is refused when (w+1) mod 8 equals `inv_win_i`. The pointer then stays unchanged, and `unf_o` is high for exactly the one cycle after the command edge.
- R9: When save and restore are asserted together, both are ignored. The pointer does not move and neither flag rises.
- R10: If the write port targets the register a read port selects in the same cycle, that read port returns the write data in that cycle, before the clock edge. Register 0 is the exception and still reads 0.
- R11: A write issued in the same cycle as a save or restore goes to the window in force before the pointer moves.
- R12: Both read ports are combinational: a change of read address alone changes the read data within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr0_i | input | 5 | Architectural register for read port 0 |
| rd_data0_o | output | DW | Read data, port 0 |
| rd_addr1_i | input | 5 | Architectural register for read port 1 |
| rd_data1_o | output | DW | Read data, port 1 |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Architectural register to write |
| wr_data_i | input | DW | Write data |
| save_i | input | 1 | Move the window down by one |
| restore_i | input | 1 | Move the window up by one |
| inv_win_i | input | log2(NWIN) | Index of the window that may not be entered |
| cwp_o | output | log2(NWIN) | Current window pointer |
| ovf_o | output | 1 | Refused-save pulse |
| unf_o | output | 1 | Refused-restore pulse |

## Verification
The pointer properties compare each move with the `inv_win_i` value present at the command edge, so they assume that input is stable across that edge. The bench changes it only between commands, at least one full cycle before the next save or restore. The forwarding property assumes the write address and read address are sampled together in one cycle, and the bench drives each write and read of a pair from a single task step for that reason. No stimulus sets `inv_win_i` equal to the current pointer.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    localparam int unsigned ARCH_REGS = 32;
    localparam int unsigned GROUP     = 8;
    localparam int unsigned AW        = $clog2(ARCH_REGS);

    typedef enum logic [1:0] {
        BANK_GLOBAL = 2'd0,
        BANK_OUT    = 2'd1,
        BANK_LOCAL  = 2'd2,
        BANK_IN     = 2'd3
    } bank_e;
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    parameter int unsigned WW   = $clog2(NWIN),
    parameter int unsigned PW   = 8
) (
    input  logic [AW-1:0] arch_i,
    input  logic [WW-1:0] cwp_i,
    output logic [PW-1:0] phys_o
);
    localparam int unsigned WSPAN = 2 * GROUP;

    bank_e          bank;
    logic [2:0]     off;
    logic [WW-1:0]  prev_win;
    logic [PW-1:0]  cur_base;
    logic [PW-1:0]  prev_base;

    always_comb begin
        bank      = bank_e'(arch_i[4:3]);
        off       = arch_i[2:0];
        prev_win  = (cwp_i == '0) ? WW'(NWIN - 1) : cwp_i - 1'b1;
        cur_base  = PW'(GROUP) + PW'(cwp_i) * PW'(WSPAN);
        prev_base = PW'(GROUP) + PW'(prev_win) * PW'(WSPAN);
        unique case (bank)
            BANK_GLOBAL: phys_o = PW'(arch_i);
            BANK_OUT:    phys_o = prev_base + PW'(off);
            BANK_LOCAL:  phys_o = cur_base + PW'(GROUP) + PW'(off);
            default:     phys_o = cur_base + PW'(off);
        endcase
    end
endmodule

// File: rtl/wrf_cwp_ctrl.sv
module wrf_cwp_ctrl #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned WW   = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_i,
    input  logic          restore_i,
    input  logic [WW-1:0] inv_win_i,
    output logic [WW-1:0] cwp_o,
    output logic          ovf_o,
    output logic          unf_o
);
    typedef struct packed {
        logic [WW-1:0] cwp;
        logic          ovf;
        logic          unf;
    } st_t;

    st_t           st_d, st_q;
    logic [WW-1:0] down_w, up_w;

    always_comb begin
        down_w = (st_q.cwp == '0) ? WW'(NWIN - 1) : st_q.cwp - 1'b1;
        up_w   = (st_q.cwp == WW'(NWIN - 1)) ? '0 : st_q.cwp + 1'b1;
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (save_i && !restore_i) begin
            if (down_w == inv_win_i) st_d.ovf = 1'b1;
            else                     st_d.cwp = down_w;
        end else if (restore_i && !save_i) begin
            if (up_w == inv_win_i)   st_d.unf = 1'b1;
            else                     st_d.cwp = up_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp_o = st_q.cwp;
    assign ovf_o = st_q.ovf;
    assign unf_o = st_q.unf;
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int unsigned DEPTH = 136,
    parameter int unsigned PW    = 8,
    parameter int unsigned DW    = 32,
    parameter int unsigned NRD   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [PW-1:0]           waddr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic [NRD-1:0][PW-1:0]  raddr_i,
    output logic [NRD-1:0][DW-1:0]  rdata_o
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic          wr_live;

    assign wr_live = we_i && (waddr_i != '0);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (wr_live) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (raddr_i[p] == '0)                    rdata_o[p] = '0;
            else if (wr_live && waddr_i == raddr_i[p]) rdata_o[p] = wdata_i;
            else                                     rdata_o[p] = mem_q[raddr_i[p]];
        end
    end
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile
    import wrf_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    parameter int unsigned DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [4:0]               rd_addr0_i,
    output logic [DW-1:0]            rd_data0_o,
    input  logic [4:0]               rd_addr1_i,
    output logic [DW-1:0]            rd_data1_o,
    input  logic                     wr_en_i,
    input  logic [4:0]               wr_addr_i,
    input  logic [DW-1:0]            wr_data_i,
    input  logic                     save_i,
    input  logic                     restore_i,
    input  logic [$clog2(NWIN)-1:0]  inv_win_i,
    output logic [$clog2(NWIN)-1:0]  cwp_o,
    output logic                     ovf_o,
    output logic                     unf_o
);
    localparam int unsigned WW    = $clog2(NWIN);
    localparam int unsigned DEPTH = GROUP + NWIN * 2 * GROUP;
    localparam int unsigned PW    = $clog2(DEPTH);
    localparam int unsigned NPORT = 3;

    logic [NPORT-1:0][AW-1:0] arch;
    logic [NPORT-1:0][PW-1:0] phys;
    logic [1:0][PW-1:0]       rd_phys;
    logic [1:0][DW-1:0]       rd_data;

    assign arch[0] = rd_addr0_i;
    assign arch[1] = rd_addr1_i;
    assign arch[2] = wr_addr_i;

    wrf_cwp_ctrl #(.NWIN(NWIN), .WW(WW)) u_cwp (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_i    (save_i),
        .restore_i (restore_i),
        .inv_win_i (inv_win_i),
        .cwp_o     (cwp_o),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    for (genvar k = 0; k < NPORT; k++) begin : g_map
        wrf_addr_map #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_map (
            .arch_i (arch[k]),
            .cwp_i  (cwp_o),
            .phys_o (phys[k])
        );
    end

    assign rd_phys[0] = phys[0];
    assign rd_phys[1] = phys[1];

    wrf_storage #(.DEPTH(DEPTH), .PW(PW), .DW(DW), .NRD(2)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i),
        .waddr_i (phys[2]),
        .wdata_i (wr_data_i),
        .raddr_i (rd_phys),
        .rdata_o (rd_data)
    );

    assign rd_data0_o = rd_data[0];
    assign rd_data1_o = rd_data[1];
endmodule

// File: rtl/wrf_regfile_chk.sv
module wrf_regfile_chk #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned DW   = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [4:0]               rd_addr0_i,
    input logic [DW-1:0]            rd_data0_o,
    input logic [4:0]               rd_addr1_i,
    input logic [DW-1:0]            rd_data1_o,
    input logic                     wr_en_i,
    input logic [4:0]               wr_addr_i,
    input logic [DW-1:0]            wr_data_i,
    input logic                     save_i,
    input logic                     restore_i,
    input logic [$clog2(NWIN)-1:0]  inv_win_i,
    input logic [$clog2(NWIN)-1:0]  cwp_o,
    input logic                     ovf_o,
    input logic                     unf_o
);
    localparam int unsigned WW = $clog2(NWIN);
    logic [WW-1:0] down_w, up_w;
    assign down_w = (cwp_o == '0) ? WW'(NWIN - 1) : cwp_o - 1'b1;
    assign up_w   = (cwp_o == WW'(NWIN - 1)) ? '0 : cwp_o + 1'b1;

    a_r2_port0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr0_i == 5'd0) |-> (rd_data0_o == '0));
    a_r2_port1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr1_i == 5'd0) |-> (rd_data1_o == '0));
    a_r10_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != 5'd0 && wr_addr_i == rd_addr0_i) |-> (rd_data0_o == wr_data_i));
    a_r6_save_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && down_w != inv_win_i) |=> (cwp_o == $past(down_w) && !ovf_o));
    a_r6_restore_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && up_w != inv_win_i) |=> (cwp_o == $past(up_w) && !unf_o));
    a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && down_w == inv_win_i) |=> (ovf_o && $stable(cwp_o)));
    a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && up_w == inv_win_i) |=> (unf_o && $stable(cwp_o)));
    a_r9_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && restore_i) |=> ($stable(cwp_o) && !ovf_o && !unf_o));
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));
endmodule

bind wrf_regfile wrf_regfile_chk #(.NWIN(NWIN), .DW(DW)) u_chk (.*);

// File: tb/wrf_regfile_tb.sv
module wrf_regfile_tb;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_addr0_i = '0, rd_addr1_i = '0, wr_addr_i = '0;
    logic [DW-1:0] rd_data0_o, rd_data1_o, wr_data_i = '0;
    logic          wr_en_i = 1'b0, save_i = 1'b0, restore_i = 1'b0;
    logic [2:0]    inv_win_i = 3'd4;
    logic [2:0]    cwp_o;
    logic          ovf_o, unf_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wrf_regfile #(.NWIN(8), .DW(DW)) u_dut (.*);

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        cyc();
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [DW-1:0] d);
        rd_addr0_i = a;
        #1;
        d = rd_data0_o;
    endtask

    task automatic do_save();
        save_i = 1'b1; cyc(); save_i = 1'b0;
    endtask

    task automatic do_restore();
        restore_i = 1'b1; cyc(); restore_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        chk("R1 cwp", DW'(cwp_o), 0);
        chk("R1 ovf", DW'(ovf_o), 0);
        chk("R1 unf", DW'(unf_o), 0);
        rd(5'd20, d); chk("R1 reg20", d, 0);
    endtask

    task automatic t_zero();
        logic [DW-1:0] d;
        wr(5'd0, 32'hDEAD_BEEF);
        rd(5'd0, d); chk("R2 port0", d, 0);
        rd_addr1_i = 5'd0; #1; chk("R2 port1", rd_data1_o, 0);
    endtask

    task automatic t_globals();
        logic [DW-1:0] d;
        for (int i = 1; i < 8; i++) wr(5'(i), 32'h6000 + i);
        do_save(); do_save();
        for (int i = 1; i < 8; i++) begin rd(5'(i), d); chk("R3 after saves", d, 32'h6000 + i); end
        do_restore(); do_restore();
        rd(5'd7, d); chk("R3 after restores", d, 32'h6007);
    endtask

    task automatic t_overlap();
        logic [DW-1:0] d;
        for (int i = 0; i < 8; i++) wr(5'(8 + i), 32'h100 + i);
        wr(5'd16, 32'h55);
        do_save();
        chk("R6 save wraps to 7", DW'(cwp_o), 7);
        for (int i = 0; i < 8; i++) begin rd(5'(24 + i), d); chk("R5 outs to ins", d, 32'h100 + i); end
        rd(5'd16, d); chk("R4 local fresh", d, 0);
        wr(5'd16, 32'hAA);
        wr(5'd27, 32'h777);
        do_restore();
        chk("R6 restore wraps to 0", DW'(cwp_o), 0);
        rd(5'd11, d); chk("R5 ins to outs", d, 32'h777);
        rd(5'd16, d); chk("R4 local kept", d, 32'h55);
    endtask

    task automatic t_write_shift();
        logic [DW-1:0] d;
        wr_en_i = 1'b1; wr_addr_i = 5'd18; wr_data_i = 32'hABC; save_i = 1'b1;
        cyc();
        wr_en_i = 1'b0; save_i = 1'b0;
        rd(5'd18, d); chk("R11 not in new window", d, 0);
        do_restore();
        rd(5'd18, d); chk("R11 old window", d, 32'hABC);
    endtask

    task automatic t_overflow();
        inv_win_i = 3'd7; cyc();
        do_save();
        chk("R7 ovf pulse", DW'(ovf_o), 1);
        chk("R7 cwp held", DW'(cwp_o), 0);
        cyc();
        chk("R7 ovf one cycle", DW'(ovf_o), 0);
    endtask

    task automatic t_underflow();
        inv_win_i = 3'd1; cyc();
        do_restore();
        chk("R8 unf pulse", DW'(unf_o), 1);
        chk("R8 cwp held", DW'(cwp_o), 0);
        chk("R8 no ovf", DW'(ovf_o), 0);
        cyc();
        chk("R8 unf one cycle", DW'(unf_o), 0);
        inv_win_i = 3'd4; cyc();
    endtask

    task automatic t_both();
        save_i = 1'b1; restore_i = 1'b1;
        cyc();
        save_i = 1'b0; restore_i = 1'b0;
        chk("R9 cwp held", DW'(cwp_o), 0);
        chk("R9 no ovf", DW'(ovf_o), 0);
        chk("R9 no unf", DW'(unf_o), 0);
    endtask

    task automatic t_forward();
        wr_en_i = 1'b1; wr_addr_i = 5'd20; wr_data_i = 32'h1234_5678;
        rd_addr0_i = 5'd20;
        #1; chk("R10 forward", rd_data0_o, 32'h1234_5678);
        wr_addr_i = 5'd0; rd_addr1_i = 5'd0;
        #1; chk("R10 r0 not forwarded", rd_data1_o, 0);
        cyc();
        wr_en_i = 1'b0;
    endtask

    task automatic t_comb_read();
        rd_addr1_i = 5'd3; #1; chk("R12 port1 g3", rd_data1_o, 32'h6003);
        rd_addr1_i = 5'd5; #1; chk("R12 port1 g5", rd_data1_o, 32'h6005);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        t_reset();
        t_zero();
        t_globals();
        t_overlap();
        t_write_shift();
        t_overflow();
        t_underflow();
        t_both();
        t_forward();
        t_comb_read();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule